// File: doc/BRIEF.md
# Dual-Channel Sample Output Multiplexer

This block is the digital back end of a two-channel (I and Q) sampling front end. On every rising edge of the sample clock it takes one word for each channel, both captured at the same instant, and sends them through two delay lines of different length. The I word reaches the shared output bus seven sample periods after capture. The Q word arrives half a period later, so it lines up with the falling sample edge. A select input chooses which delay line drives the bus. An active-low output enable releases the bus, while capture and delay continue underneath.

The block runs on a clock at twice the sample rate. An internal phase flag marks the two halves of each sample period: it is 1 in the half that opens with a rising sample edge and 0 in the other half. The select input is registered on every double-rate edge. When it follows the phase of the next half, the bus shows I data in the high half and Q data in the low half, which gives an interleaved I/Q stream. The tri-state pins are modelled as a data word plus a drive-enable flag.

Top module: `dual_chan_outmux`

## Requirements
- R1: After reset the phase flag `half_hi` is 0 and toggles on every clock edge. Inputs are captured only at edges where `half_hi` is 0 (the rising sample edge), and input values present at the other edges are ignored.
- R2: Words pass bit for bit: bit 9 is the MSB and bit 0 the LSB, on input and on output alike.
- R3: `sel` is sampled at each clock edge. A 1 puts I-channel data on the bus for the following half period and a 0 puts Q-channel data there.
- R4: With `sel` high, the bus after clock edge n carries the I word captured at the latest capture edge at or before edge n-14 (7 sample periods).
- R5: With `sel` low, the bus after clock edge n carries the Q word captured at the latest capture edge at or before edge n-15 (7.5 sample periods).
- R6: When `sel` is driven to 1 for high halves and 0 for low halves, the I and Q words captured on the same edge appear one clock (half a sample period) apart, with I first.
- R7: While `oe_n` is high, `bus_drive` is 0 and `bus_data` is 0. Capture and both delay lines keep advancing.
- R8: When `oe_n` returns low, the bus at once shows the word that is current in the pipeline at that point. No word is replayed or held back.
- R9: Synchronous reset clears both delay lines, so `bus_data` is 0 and `bus_valid` is 0 during reset and until real data reaches the output.
- R10: `bus_valid` after edge n (edges counted from the first edge after reset) is 1 only if the channel shown has reached its latency: n >= 14 for I and n >= 15 for Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| i_word | input | 10 | I-channel sample word |
| q_word | input | 10 | Q-channel sample word |
| sel | input | 1 | Channel select for the next half period, 1 = I, 0 = Q |
| oe_n | input | 1 | Output enable, active low |
| half_hi | output | 1 | Phase flag, 1 in the half that opens with a rising sample edge |
| bus_data | output | 10 | Shared output word, zero while not driven |
| bus_drive | output | 1 | Drive enable of the shared bus |
| bus_valid | output | 1 | The shown channel has reached its latency since reset |

## Verification
Releasing the output enable and switching the channel can fall on the same clock edge, and the bench makes this happen on purpose. It returns `oe_n` low at the edge where the select-follows-clock pattern switches the bus from one delay line to the other. A new word arrives there as well, so three effects meet in one cycle. A behavioural model indexed by edge number predicts the word for that edge, and the bench compares it with the first driven value. A replayed word, a held word or one shifted by a half period would show up as a mismatch against the model.

// File: rtl/dual_chan_outmux.sv
module dual_chan_outmux #(
  parameter int W     = 10,
  parameter int I_DLY = 14,
  parameter int Q_DLY = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] i_word,
  input  logic [W-1:0] q_word,
  input  logic         sel,
  input  logic         oe_n,
  output logic         half_hi,
  output logic [W-1:0] bus_data,
  output logic         bus_drive,
  output logic         bus_valid
);

  localparam int IL = I_DLY - 1;
  localparam int QL = Q_DLY - 1;
  localparam int CW = $clog2(Q_DLY + 1);

  logic [W-1:0]  i_hold, q_hold;
  logic [W-1:0]  i_line [IL];
  logic [W-1:0]  q_line [QL];
  logic [W-1:0]  bus_q;
  logic [CW-1:0] cnt;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_hi <= 1'b0;
      i_hold  <= '0;
      q_hold  <= '0;
      cnt     <= '0;
      bus_q   <= '0;
      valid_q <= 1'b0;
      for (int k = 0; k < IL; k++) i_line[k] <= '0;
      for (int k = 0; k < QL; k++) q_line[k] <= '0;
    end else begin
      half_hi <= ~half_hi;
      if (!half_hi) begin
        i_hold <= i_word;
        q_hold <= q_word;
      end
      i_line[0] <= i_hold;
      for (int k = 1; k < IL; k++) i_line[k] <= i_line[k-1];
      q_line[0] <= q_hold;
      for (int k = 1; k < QL; k++) q_line[k] <= q_line[k-1];
      if (cnt != CW'(Q_DLY)) cnt <= cnt + 1'b1;
      bus_q   <= sel ? i_line[IL-1] : q_line[QL-1];
      valid_q <= sel ? (cnt >= CW'(I_DLY)) : (cnt >= CW'(Q_DLY));
    end
  end

  assign bus_drive = ~oe_n;
  assign bus_data  = bus_drive ? bus_q : '0;
  assign bus_valid = valid_q;

  p_phase_lo_r1: assert property (@(posedge clk) disable iff (rst)
    !half_hi |=> half_hi);
  p_phase_hi_r1: assert property (@(posedge clk) disable iff (rst)
    half_hi |=> !half_hi);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    half_hi |=> ($stable(i_hold) && $stable(q_hold)));
  p_valid_early_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(I_DLY)) |=> !bus_valid);
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(Q_DLY)) |=> (cnt == CW'(Q_DLY)));
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bus_q == '0 && !bus_valid));

endmodule

// File: tb/dual_chan_outmux_tb.sv
module dual_chan_outmux_tb_top;
  localparam int N = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] i_word = '0, q_word = '0;
  logic       sel = 1'b0, oe_n = 1'b0;
  logic       half_hi, bus_drive, bus_valid;
  logic [9:0] bus_data;

  logic [9:0] ai [0:N-1];
  logic [9:0] aq [0:N-1];
  bit         asel [0:N-1];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_chan_outmux dut_i (
    .clk(clk), .rst(rst), .i_word(i_word), .q_word(q_word), .sel(sel),
    .oe_n(oe_n), .half_hi(half_hi), .bus_data(bus_data),
    .bus_drive(bus_drive), .bus_valid(bus_valid)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit follow_mode(input int n);
    return (n < 60) || (n >= 140);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset bus_data", bus_data, 0);
    chk("R9 reset bus_valid", bus_valid, 0);
    chk("R1 reset half_hi", half_hi, 0);
    for (int n = 0; n < N; n++) begin
      int k;
      int m;
      int exp_d;
      bit exp_v;
      string tag;
      rst = 1'b0;
      k = n / 2;
      if (n % 2 == 0) begin
        i_word = 10'((k * 7 + 3) % 1024);
        q_word = 10'(1023 - k * 5);
      end else begin
        i_word = 10'h155;
        q_word = 10'h2AA;
      end
      if (follow_mode(n)) sel = (n % 2 == 0);
      else sel = (n < 100);
      oe_n = (n >= 150 && n < 160);
      ai[n] = i_word;
      aq[n] = q_word;
      asel[n] = sel;
      @(posedge clk);
      @(negedge clk);
      if (asel[n]) begin
        m = n - 14;
        exp_d = (m >= 0) ? int'(ai[m - (m % 2)]) : 0;
        exp_v = (n >= 14);
      end else begin
        m = n - 15;
        exp_d = (m >= 0) ? int'(aq[m - (m % 2)]) : 0;
        exp_v = (n >= 15);
      end
      if (oe_n) begin
        exp_d = 0;
        tag = "R7 bus released";
      end else if (n == 160 || n == 161) tag = "R8 bus re-enabled";
      else if (follow_mode(n)) tag = "R6 interleave R2";
      else if (asel[n]) tag = "R4 I latency R3 R2";
      else tag = "R5 Q latency R3 R2";
      chk(tag, bus_data, exp_d);
      chk("R7 bus_drive", bus_drive, oe_n ? 0 : 1);
      chk("R10 bus_valid", bus_valid, exp_v);
      chk("R1 half_hi", half_hi, (n % 2 == 0) ? 1 : 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule